// File: doc/BRIEF.md
# Dual Down-Counter Timer Peripheral

This peripheral holds two independent 32-bit decrementing counters reached through a simple APB-style register port. Each counter keeps a current value, a reload value and an 8-bit mode register. Each counter has its own interrupt line. The interrupt is raised when the counter steps down to zero and stays raised until software writes to the counter's clear register. The counter can run periodically (reloading from the background value), free-running (wrapping to all ones), or one-shot (halting at zero). It can count over the full 32 bits or only over the lower 16 bits.

A debug halt input freezes both counters while it is high. A test override lets software drive the interrupt lines straight from a register. A fixed bank of identification bytes near the top of the 4 KB window is readable. The synchronous reset input acts as the warm system reset.

Counter 1 occupies offsets 0x00–0x1F and counter 2 occupies 0x20–0x3F. Within each 32-byte bank the word slots are:

| Slot | Register |
|------|----------|
| +0x00 | load |
| +0x04 | current value |
| +0x08 | mode |
| +0x0C | interrupt clear |
| +0x10 | raw status |
| +0x14 | masked status |
| +0x18 | background load |

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset, each current value reads 0xFFFFFFFF, each load and background load reads 0, each mode register reads 0x20, raw and masked status read 0, the test-mode register reads 0, and both interrupt outputs are low.
- R2: The mode register is 8 bits and reads back as written. Its bits are:
  - bit 7: count enable
  - bit 6: periodic select
  - bit 5: interrupt enable
  - bit 1: 32-bit size (16-bit when clear)
  - bit 0: one-shot

  A counter whose enable bit is clear holds its value.
- R3: A write to load (+0x00) sets the current value and the reload value at the same edge. Reads of either +0x00 or +0x18 return the reload value.
- R4: A write to background load (+0x18) changes only the reload value; the current value is untouched.
- R5: An enabled counter decrements by one per clock. In periodic mode, a counter at zero reloads from the reload value on its next step.
- R6: In free-running mode, a counter at zero wraps to 0xFFFFFFFF in 32-bit size, or to 0x0000FFFF in 16-bit size (16-bit size counts only the low half).
- R7: In one-shot mode, a counter at zero stays at zero.
- R8: Raw status (+0x10, bit 0) sets on the edge where the counter steps from one to zero. A write of any data to interrupt clear (+0x0C) clears it. When both happen at the same edge, the set wins.
- R9: Masked status (+0x14, bit 0) equals raw status ANDed with the interrupt enable bit. While test mode is off, interrupt output bit i follows counter i+1's masked status.
- R10: While the debug halt input is high, neither counter changes value, except through a load write.
- R11: When bit 0 of the test-mode register at 0xF00 is set, interrupt output bits [1:0] equal the 2-bit override written to 0xF04. That override register is write-only and reads as 0.
- R12: Word offsets 0xFD0 to 0xFFC read, in ascending address order, 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to them are ignored.
- R13: Unmapped or unaligned offsets read 0. Writes to read-only or unmapped offsets (current value, raw status, masked status, +0x1C, identification) change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high warm reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| dbg_halt | input | 1 | Freezes both counters while high |
| irq | output | 2 | Per-counter interrupt, bit 0 = counter 1 |

## Verification
A wrong reload value, mode bit or step count shows up on the current-value read within one clock. The bench samples that register on the exact cycle it is expected to reach zero, reload or wrap. A wrong raw status or a lost clear-versus-set priority appears on the interrupt line at the same edge as the zero step. The masked-status and test-mode paths are combinational, so a fault there is visible on `irq` in the cycle after the controlling register write.

// File: rtl/dct_pkg.sv
package dct_pkg;
    localparam int CNT_W = 32;

    // Mode register bit positions
    localparam int MB_EN     = 7;
    localparam int MB_PERIOD = 6;
    localparam int MB_IE     = 5;
    localparam int MB_SIZE32 = 1;
    localparam int MB_ONESHT = 0;
    localparam logic [7:0] MODE_RST = 8'h20;

    // Word slots inside one counter bank (paddr[4:2])
    localparam logic [2:0] SLOT_LOAD  = 3'd0;
    localparam logic [2:0] SLOT_VALUE = 3'd1;
    localparam logic [2:0] SLOT_MODE  = 3'd2;
    localparam logic [2:0] SLOT_CLR   = 3'd3;
    localparam logic [2:0] SLOT_RAW   = 3'd4;
    localparam logic [2:0] SLOT_MSK   = 3'd5;
    localparam logic [2:0] SLOT_BG    = 3'd6;

    localparam logic [11:0] OFF_TMODE = 12'hF00;
    localparam logic [11:0] OFF_TOVR  = 12'hF04;

    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic [CNT_W-1:0] reload;
        logic [7:0]       mode;
        logic             raw;
    } cnt_state_t;
endpackage

// File: rtl/dct_idrom.sv
module dct_idrom (
    input  logic [9:0] word_addr,
    output logic       hit,
    output logic [7:0] id_byte
);
    logic [3:0] idx;

    always_comb begin
        hit = (word_addr[9:2] >= 8'hFD);
        idx = word_addr[3:0] - 4'd4;
        case (idx)
            4'd0:    id_byte = 8'h04;
            4'd1:    id_byte = 8'h00;
            4'd2:    id_byte = 8'h00;
            4'd3:    id_byte = 8'h00;
            4'd4:    id_byte = 8'h23;
            4'd5:    id_byte = 8'hB8;
            4'd6:    id_byte = 8'h1B;
            4'd7:    id_byte = 8'h00;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hF0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/dct_counter.sv
module dct_counter
    import dct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             halt,
    input  logic             wr_load,
    input  logic             wr_bg,
    input  logic             wr_mode,
    input  logic             wr_clr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] value,
    output logic [CNT_W-1:0] reload,
    output logic [7:0]       mode,
    output logic             raw,
    output logic             masked
);
    localparam int HALF = CNT_W / 2;
    localparam logic [CNT_W-1:0] LOW_MASK = {{(CNT_W-HALF){1'b0}}, {HALF{1'b1}}};
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_state_t s_d, s_q;
    logic [CNT_W-1:0] size_mask;
    logic [CNT_W-1:0] cur;
    logic             at_zero;
    logic             step;
    logic             hit_zero;

    always_comb begin
        s_d       = s_q;
        size_mask = s_q.mode[MB_SIZE32] ? '1 : LOW_MASK;
        cur       = s_q.value & size_mask;
        at_zero   = (cur == '0);
        step      = s_q.mode[MB_EN] && !halt && !(s_q.mode[MB_ONESHT] && at_zero);
        hit_zero  = 1'b0;

        if (step) begin
            if (at_zero) begin
                s_d.value = s_q.mode[MB_PERIOD] ? (s_q.reload & size_mask) : size_mask;
            end else begin
                s_d.value = cur - ONE;
                hit_zero  = (cur == ONE);
            end
        end

        if (wr_mode) s_d.mode   = wdata[7:0];
        if (wr_bg)   s_d.reload = wdata;
        if (wr_load) begin
            s_d.reload = wdata;
            s_d.value  = wdata;
            hit_zero   = 1'b0;
        end

        if (wr_clr)   s_d.raw = 1'b0;
        if (hit_zero) s_d.raw = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.value  <= '1;
            s_q.reload <= '0;
            s_q.mode   <= MODE_RST;
            s_q.raw    <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign value  = s_q.value;
    assign reload = s_q.reload;
    assign mode   = s_q.mode;
    assign raw    = s_q.raw;
    assign masked = s_q.raw & s_q.mode[MB_IE];
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
    import dct_pkg::*;
#(
    parameter int NUM_CNT = 2,
    parameter int ADDR_W  = 12,
    parameter int DW      = CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DW-1:0]     pwdata,
    output logic [DW-1:0]     prdata,
    input  logic              dbg_halt,
    output logic [NUM_CNT-1:0] irq
);
    localparam int BANK_W = ADDR_W - 5;

    typedef struct packed {
        logic               tmode;
        logic [NUM_CNT-1:0] tovr;
    } tctl_t;

    tctl_t t_d, t_q;

    logic                           wr_en;
    logic                           aligned;
    logic [BANK_W-1:0]              bank;
    logic [2:0]                     slot;
    logic [NUM_CNT-1:0]             wr_load_v, wr_bg_v, wr_mode_v, wr_clr_v;
    logic [NUM_CNT-1:0][DW-1:0]     cnt_val, cnt_rel;
    logic [NUM_CNT-1:0][7:0]        cnt_mode;
    logic [NUM_CNT-1:0]             cnt_raw, cnt_msk, cnt_ie;
    logic                           id_hit;
    logic [7:0]                     id_byte;

    assign wr_en   = psel & penable & pwrite;
    assign aligned = (paddr[1:0] == 2'b00);
    assign bank    = paddr[ADDR_W-1:5];
    assign slot    = paddr[4:2];

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic sel;
        assign sel          = wr_en && aligned && (bank == BANK_W'(i));
        assign wr_load_v[i] = sel && (slot == SLOT_LOAD);
        assign wr_bg_v[i]   = sel && (slot == SLOT_BG);
        assign wr_mode_v[i] = sel && (slot == SLOT_MODE);
        assign wr_clr_v[i]  = sel && (slot == SLOT_CLR);
        assign cnt_ie[i]    = cnt_mode[i][MB_IE];

        dct_counter u_cnt (
            .clk     (clk),
            .rst     (rst),
            .halt    (dbg_halt),
            .wr_load (wr_load_v[i]),
            .wr_bg   (wr_bg_v[i]),
            .wr_mode (wr_mode_v[i]),
            .wr_clr  (wr_clr_v[i]),
            .wdata   (pwdata),
            .value   (cnt_val[i]),
            .reload  (cnt_rel[i]),
            .mode    (cnt_mode[i]),
            .raw     (cnt_raw[i]),
            .masked  (cnt_msk[i])
        );
    end

    dct_idrom u_id (
        .word_addr (paddr[ADDR_W-1:2]),
        .hit       (id_hit),
        .id_byte   (id_byte)
    );

    // Test-mode control registers
    always_comb begin
        t_d = t_q;
        if (wr_en && paddr == OFF_TMODE) t_d.tmode = pwdata[0];
        if (wr_en && paddr == OFF_TOVR)  t_d.tovr  = pwdata[NUM_CNT-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign irq = t_q.tmode ? t_q.tovr : cnt_msk;

    // Read mux
    always_comb begin
        prdata = '0;
        if (!aligned) begin
            prdata = '0;
        end else if (id_hit) begin
            prdata = {{(DW-8){1'b0}}, id_byte};
        end else if (paddr == OFF_TMODE) begin
            prdata = {{(DW-1){1'b0}}, t_q.tmode};
        end else begin
            for (int i = 0; i < NUM_CNT; i++) begin
                if (bank == BANK_W'(i)) begin
                    case (slot)
                        SLOT_LOAD,
                        SLOT_BG:    prdata = cnt_rel[i];
                        SLOT_VALUE: prdata = cnt_val[i];
                        SLOT_MODE:  prdata = {{(DW-8){1'b0}}, cnt_mode[i]};
                        SLOT_RAW:   prdata = {{(DW-1){1'b0}}, cnt_raw[i]};
                        SLOT_MSK:   prdata = {{(DW-1){1'b0}}, cnt_msk[i]};
                        default:    prdata = '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
    parameter int NUM_CNT = 2,
    parameter int DW      = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       dbg_halt,
    input logic [NUM_CNT-1:0]         irq,
    input logic                       tmode,
    input logic [NUM_CNT-1:0]         tovr,
    input logic [NUM_CNT-1:0][DW-1:0] cnt_val,
    input logic [NUM_CNT-1:0][7:0]    cnt_mode,
    input logic [NUM_CNT-1:0]         cnt_raw,
    input logic [NUM_CNT-1:0]         cnt_ie,
    input logic [NUM_CNT-1:0]         wr_load_v
);
    localparam int HALF = DW / 2;

    // R11: test override drives the interrupt lines
    a_r11_override: assert property (@(posedge clk) disable iff (rst)
        tmode |-> (irq == tovr));

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        // R10: debug halt freezes the count
        a_r10_halt_freeze: assert property (@(posedge clk) disable iff (rst)
            (dbg_halt && !wr_load_v[i]) |=> (cnt_val[i] == $past(cnt_val[i])));

        // R7: one-shot counter parked at zero stays there
        a_r7_oneshot_park: assert property (@(posedge clk) disable iff (rst)
            (cnt_mode[i][7] && cnt_mode[i][0] && cnt_val[i] == '0 && !wr_load_v[i])
            |=> (cnt_val[i] == '0));

        // R8: raw status only rises with the counter landing on zero
        a_r8_raw_on_zero: assert property (@(posedge clk) disable iff (rst)
            $rose(cnt_raw[i]) |-> (cnt_val[i][HALF-1:0] == '0));

        // R9: outside test mode the line follows gated raw status
        a_r9_masked_line: assert property (@(posedge clk) disable iff (rst)
            !tmode |-> (irq[i] == (cnt_raw[i] & cnt_ie[i])));
    end
endmodule

bind dual_countdown_timer dct_checker #(.NUM_CNT(NUM_CNT), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dbg_halt  (dbg_halt),
    .irq       (irq),
    .tmode     (t_q.tmode),
    .tovr      (t_q.tovr),
    .cnt_val   (cnt_val),
    .cnt_mode  (cnt_mode),
    .cnt_raw   (cnt_raw),
    .cnt_ie    (cnt_ie),
    .wr_load_v (wr_load_v)
);

// File: tb/sim_dual_countdown_timer.sv
module sim_dual_countdown_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        dbg_halt = 1'b0;
    logic [1:0]  irq;

    int checks = 0;
    int failures = 0;
    logic [31:0] rv, keep;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_countdown_timer u0 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .dbg_halt(dbg_halt), .irq(irq)
    );

    // {requirement number, offset, expected read data} after reset
    localparam logic [47:0] VEC [NVEC] = '{
        {4'd1,  12'h000, 32'h0000_0000},   // R1 load
        {4'd1,  12'h004, 32'hFFFF_FFFF},   // R1 value
        {4'd1,  12'h008, 32'h0000_0020},   // R1 mode
        {4'd1,  12'h010, 32'h0000_0000},   // R1 raw
        {4'd1,  12'h014, 32'h0000_0000},   // R1 masked
        {4'd1,  12'h018, 32'h0000_0000},   // R1 background
        {4'd1,  12'h020, 32'h0000_0000},
        {4'd1,  12'h024, 32'hFFFF_FFFF},
        {4'd1,  12'h028, 32'h0000_0020},
        {4'd1,  12'h030, 32'h0000_0000},
        {4'd1,  12'h034, 32'h0000_0000},
        {4'd1,  12'h038, 32'h0000_0000},
        {4'd1,  12'hF00, 32'h0000_0000},
        {4'd12, 12'hFD0, 32'h0000_0004},   // R12 identification bytes
        {4'd12, 12'hFD4, 32'h0000_0000},
        {4'd12, 12'hFD8, 32'h0000_0000},
        {4'd12, 12'hFDC, 32'h0000_0000},
        {4'd12, 12'hFE0, 32'h0000_0023},
        {4'd12, 12'hFE4, 32'h0000_00B8},
        {4'd12, 12'hFE8, 32'h0000_001B},
        {4'd12, 12'hFEC, 32'h0000_0000},
        {4'd12, 12'hFF0, 32'h0000_000D},
        {4'd12, 12'hFF4, 32'h0000_00F0},
        {4'd12, 12'hFF8, 32'h0000_0005},
        {4'd12, 12'hFFC, 32'h0000_00B1},
        {4'd13, 12'h01C, 32'h0000_0000},   // R13 unmapped slot
        {4'd13, 12'h00C, 32'h0000_0000},   // R13 clear slot reads zero
        {4'd13, 12'h800, 32'h0000_0000},   // R13 hole
        {4'd13, 12'h005, 32'h0000_0000},   // R13 unaligned
        {4'd11, 12'hF04, 32'h0000_0000}    // R11 override is write-only
    };

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        #1;
        d = prdata;
        psel = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired got=%h exp=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        @(negedge clk);

        chk({30'd0, irq}, 32'd0, "R1 irq after reset");
        for (int i = 0; i < NVEC; i++) begin
            rd(VEC[i][43:32], rv);
            chk(rv, VEC[i][31:0], $sformatf("R%0d table offset %h", VEC[i][47:44], VEC[i][43:32]));
        end

        // R2: disabled counter holds
        tick(5);
        rd(12'h004, rv); chk(rv, 32'hFFFF_FFFF, "R2 disabled holds");

        // R3 / R4 / R5
        wr(12'h008, 32'h62);
        rd(12'h008, rv); chk(rv, 32'h62, "R2 mode readback");
        wr(12'h000, 32'd2);
        rd(12'h004, rv); chk(rv, 32'd2, "R3 load sets value");
        wr(12'h018, 32'd7);
        rd(12'h004, rv); chk(rv, 32'd2, "R4 bg keeps value");
        rd(12'h018, rv); chk(rv, 32'd7, "R4 bg readback");
        rd(12'h000, rv); chk(rv, 32'd7, "R3 load reads reload");
        wr(12'h008, 32'hE2);
        rd(12'h004, rv); chk(rv, 32'd2, "R5 start value");
        tick(1);
        rd(12'h004, rv); chk(rv, 32'd1, "R5 decrement");
        tick(1);
        rd(12'h004, rv); chk(rv, 32'd0, "R5 reach zero");
        rd(12'h010, rv); chk(rv, 32'd1, "R8 raw set at zero");
        chk({30'd0, irq}, 32'd1, "R9 irq0 high");
        tick(1);
        rd(12'h004, rv); chk(rv, 32'd7, "R5 periodic reload");

        // R9 masking, R8 clear
        wr(12'h008, 32'h62);
        rd(12'h014, rv); chk(rv, 32'd1, "R9 masked with enable");
        wr(12'h008, 32'h42);
        rd(12'h014, rv); chk(rv, 32'd0, "R9 masked without enable");
        chk({30'd0, irq}, 32'd0, "R9 irq follows masked");
        rd(12'h010, rv); chk(rv, 32'd1, "R9 raw unaffected by mask");
        wr(12'h00C, 32'hDEAD);
        rd(12'h010, rv); chk(rv, 32'd0, "R8 clear by any write");

        // R8 set wins over clear at the same edge
        wr(12'h000, 32'd3);
        wr(12'h008, 32'hC2);
        wr(12'h00C, 32'd0);
        rd(12'h010, rv); chk(rv, 32'd1, "R8 set beats clear");
        wr(12'h008, 32'h02);
        wr(12'h00C, 32'd1);
        rd(12'h010, rv); chk(rv, 32'd0, "R8 clear when idle");

        // R7 one-shot
        wr(12'h008, 32'h23);
        wr(12'h000, 32'd2);
        wr(12'h008, 32'hA3);
        rd(12'h004, rv); chk(rv, 32'd2, "R7 start");
        tick(2);
        rd(12'h004, rv); chk(rv, 32'd0, "R7 reach zero");
        chk({30'd0, irq}, 32'd1, "R7 irq at zero");
        tick(5);
        rd(12'h004, rv); chk(rv, 32'd0, "R7 parked at zero");

        // R6 free-running, 16-bit
        wr(12'h008, 32'h20);
        wr(12'h000, 32'd1);
        wr(12'h00C, 32'd0);
        wr(12'h008, 32'hA0);
        tick(1);
        rd(12'h004, rv); chk(rv, 32'd0, "R6 16-bit zero");
        tick(1);
        rd(12'h004, rv); chk(rv, 32'h0000_FFFF, "R6 16-bit wrap");
        tick(1);
        rd(12'h004, rv); chk(rv, 32'h0000_FFFE, "R6 16-bit continue");

        // R6 free-running, 32-bit
        wr(12'h008, 32'h22);
        wr(12'h000, 32'd1);
        wr(12'h008, 32'hA2);
        tick(2);
        rd(12'h004, rv); chk(rv, 32'hFFFF_FFFF, "R6 32-bit wrap");
        wr(12'h008, 32'h22);

        // R10 debug halt freezes both counters
        dbg_halt = 1'b1;
        wr(12'h028, 32'h62);
        wr(12'h020, 32'd100);
        wr(12'h028, 32'hE2);
        wr(12'h000, 32'd50);
        wr(12'h008, 32'hA2);
        tick(5);
        rd(12'h024, rv); chk(rv, 32'd100, "R10 counter2 frozen");
        rd(12'h004, rv); chk(rv, 32'd50, "R10 counter1 frozen");
        dbg_halt = 1'b0;
        tick(3);
        rd(12'h024, rv); chk(rv, 32'd97, "R10 counter2 resumes");
        rd(12'h004, rv); chk(rv, 32'd47, "R10 counter1 resumes");
        wr(12'h008, 32'h22);
        wr(12'h028, 32'h62);

        // R11 test override
        chk({30'd0, irq}, 32'd1, "R11 before override");
        wr(12'hF04, 32'h2);
        chk({30'd0, irq}, 32'd1, "R11 override idle without mode");
        wr(12'hF00, 32'h1);
        chk({30'd0, irq}, 32'd2, "R11 override drives irq");
        rd(12'hF00, rv); chk(rv, 32'd1, "R11 mode readback");
        rd(12'hF04, rv); chk(rv, 32'd0, "R11 override reads zero");
        wr(12'hF00, 32'h0);
        chk({30'd0, irq}, 32'd1, "R11 back to masked");

        // R13 / R12 ignored writes
        rd(12'h004, keep);
        wr(12'h004, 32'h1234);
        rd(12'h004, rv); chk(rv, keep, "R13 value write ignored");
        wr(12'h01C, 32'd5);
        rd(12'h01C, rv); chk(rv, 32'd0, "R13 unmapped write ignored");
        wr(12'h010, 32'd0);
        rd(12'h010, rv); chk(rv, 32'd1, "R13 raw write ignored");
        wr(12'hFE0, 32'd0);
        rd(12'hFE0, rv); chk(rv, 32'h23, "R12 id write ignored");

        finish_run();
    end
endmodule